// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Add/Subtract Unit

This unit takes two IEEE 754 binary32 operands and returns their rounded sum, or their rounded difference, together with exception flags. A one-bit select picks add or subtract for each operation. A three-bit field picks the rounding direction. Every operation spends exactly four register stages in the unit, and a new operation may enter on every clock cycle. A valid strobe travels with each operation, so the strobe on the output marks the cycle in which the result is present.

The four stages are as follows:

1. The operands are decoded. Special operands are detected here, and the operand of larger magnitude is steered to the first lane.
2. The smaller significand is shifted right to line up with the larger one, and the bits shifted out are kept as guard, round and sticky bits.
3. A Kogge-Stone parallel-prefix adder adds or subtracts the two significands.
4. Leading zeros are counted and removed, and the sum is rounded and packed.

NaN, infinity and zero operands do not depend on the arithmetic lanes. Their result is settled in the first stage and carried beside the datapath to the output.

Top module: `fp32_addsub_pipe`

## Requirements
- R1: With `in_sub`=0 and finite operands, `out_result` is the binary32 sum of `in_a` and `in_b`, correctly rounded in the selected mode. Subtraction between operands of opposite sign is handled correctly.
- R2: With `in_sub`=1, the result is `in_a` minus `in_b`. This is computed as `in_a` plus `in_b` with its sign bit inverted, and that includes operands that are zero or infinite.
- R3: An operation sampled with `in_valid`=1 on a rising edge appears on `out_result`/`out_flags`, with `out_valid`=1, right after the third rising edge that follows. Operations issued on consecutive cycles come out on consecutive cycles, in the same order.
- R4: Any NaN operand gives exactly 0x7FC00000. The invalid flag is raised only when a signalling NaN is present. A signalling NaN has an all-ones exponent, a non-zero fraction and fraction bit 22 clear.
- R5: Infinities of opposite effective sign give 0x7FC00000 with invalid set. An infinity combined with any finite value, or with an infinity of the same effective sign, gives that infinity and no flags.
- R6: `in_rm` encodings are 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, and 4 nearest-ties-away. The values 5 to 7 behave as 0.
- R7: `out_flags` bit 4 is invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow and bit 0 inexact. Bits 3 and 1 always read 0. Inexact is set exactly when the rounded result differs from the true result.
- R8: When the rounded magnitude reaches 2^128, overflow and inexact are set. The result is then infinity in modes 0 and 4, and also in the mode that rounds toward the result's own sign. In the other modes the result is the largest finite value with the result's sign.
- R9: An exact zero from operands of opposite effective sign is +0, except in mode 2, where it is -0. The sum of two zeros of the same effective sign keeps that sign.
- R10: Subnormal operands and subnormal results are handled exactly. No operand or result is flushed to zero.
- R11: When rounding carries out of the significand, the exponent goes up by one. If that carry reaches the all-ones exponent, the result overflows as in R8.
- R12: Reset clears the valid bit of every stage. Operations still in flight when reset arrives never reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks an operation on the inputs this cycle |
| in_a | input | 32 | First operand, binary32 |
| in_b | input | 32 | Second operand, binary32 |
| in_sub | input | 1 | 0 adds, 1 subtracts `in_b` from `in_a` |
| in_rm | input | 3 | Rounding mode, encoded as in R6 |
| out_valid | output | 1 | Result and flags are valid this cycle |
| out_result | output | 32 | Rounded result, binary32 |
| out_flags | output | 5 | Exception flags, laid out as in R7 |

## Verification
The assertions assume the following about the inputs:

- Reset is asserted once at start-up.
- `in_valid` is driven to a known level on every cycle after reset.
- `in_a`, `in_b`, `in_sub` and `in_rm` hold known values on any cycle in which `in_valid` is high.

Result contents are checked only when the matching valid bit is set, so idle cycles may carry any data. The stimulus holds `in_valid` low while reset is applied. It drives every field at the falling edge, and it sets all fields to known values even on idle cycles. The bit patterns of the operands are otherwise unrestricted: signalling NaNs, subnormals and extreme exponents are all fed in.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int FP_W    = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int XTRA_W  = 3;
  localparam int ALN_W   = SIG_W + XTRA_W;
  localparam int SUM_W   = ALN_W + 1;
  localparam int FLG_W   = 5;
  localparam int FLG_NV  = 4;
  localparam int FLG_OF  = 2;
  localparam int FLG_NX  = 0;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [FP_W-1:0]  QNAN     = {1'b0, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [2:0] {
    RM_RNE = 3'd0, RM_RTZ = 3'd1, RM_RDN = 3'd2, RM_RUP = 3'd3, RM_RMM = 3'd4
  } rmode_e;

  typedef struct packed {
    logic              byp;
    logic [FP_W-1:0]   byp_val;
    logic [FLG_W-1:0]  byp_flg;
    logic              eff_sub;
    logic              sign;
    logic [EXP_W-1:0]  exp;
    rmode_e            rm;
  } ctl_t;

  // Shift right by d; bits that fall off are ORed into the lowest bit.
  function automatic logic [ALN_W-1:0] align_shift(input logic [SIG_W-1:0] sig,
                                                    input logic [EXP_W-1:0] d);
    logic [2*ALN_W-1:0] wide;
    if (d >= EXP_W'(ALN_W)) return {{(ALN_W-1){1'b0}}, |sig};
    wide = {sig, {XTRA_W{1'b0}}, {ALN_W{1'b0}}} >> d;
    return {wide[2*ALN_W-1:ALN_W+1], wide[ALN_W] | (|wide[ALN_W-1:0])};
  endfunction

  function automatic logic [4:0] lead_zeros(input logic [ALN_W-1:0] v);
    logic found;
    lead_zeros = 5'(ALN_W);
    found = 1'b0;
    for (int i = ALN_W - 1; i >= 0; i--) begin
      if (v[i] && !found) begin
        lead_zeros = 5'(ALN_W - 1 - i);
        found = 1'b1;
      end
    end
  endfunction

  function automatic logic rnd_incr(input rmode_e rm, input logic sign,
                                    input logic lsb, input logic g, input logic rest);
    case (rm)
      RM_RNE:  return g & (rest | lsb);
      RM_RDN:  return sign & (g | rest);
      RM_RUP:  return !sign & (g | rest);
      RM_RMM:  return g;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/fpadd_ks_adder.sv
module fpadd_ks_adder #(
  parameter int W = 27
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int LV = $clog2(W);

  logic [W-1:0] gen [LV+1];
  logic [W-1:0] prp [LV+1];
  logic [W:0]   carry;

  assign gen[0] = a & b;
  assign prp[0] = a ^ b;

  for (genvar lv = 0; lv < LV; lv++) begin : g_level
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= (1 << lv)) begin : g_merge
        assign gen[lv+1][i] = gen[lv][i] | (prp[lv][i] & gen[lv][i-(1<<lv)]);
        assign prp[lv+1][i] = prp[lv][i] & prp[lv][i-(1<<lv)];
      end else begin : g_pass
        assign gen[lv+1][i] = gen[lv][i];
        assign prp[lv+1][i] = prp[lv][i];
      end
    end
  end

  assign carry = {gen[LV] | (prp[LV] & {W{cin}}), cin};
  assign sum   = prp[0] ^ carry[W-1:0];
  assign cout  = carry[W];
endmodule

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
  import fpadd_pkg::*;
(
  input  logic [FP_W-1:0]  a,
  input  logic [FP_W-1:0]  b,
  input  logic             sub,
  input  logic [2:0]       rm_in,
  output ctl_t             ctl,
  output logic [SIG_W-1:0] sig_l,
  output logic [SIG_W-1:0] sig_s,
  output logic [EXP_W-1:0] diff
);
  logic              sa, sb;
  logic [EXP_W-1:0]  ea, eb, el, es;
  logic [FRAC_W-1:0] fa, fb;
  logic nan_a, nan_b, snan_any, inf_a, inf_b, zero_a, zero_b, a_big;
  rmode_e rm;

  always_comb begin
    sa = a[FP_W-1];
    sb = b[FP_W-1] ^ sub;
    ea = a[FP_W-2:FRAC_W];
    eb = b[FP_W-2:FRAC_W];
    fa = a[FRAC_W-1:0];
    fb = b[FRAC_W-1:0];
    nan_a  = (ea == EXP_ONES) && (fa != '0);
    nan_b  = (eb == EXP_ONES) && (fb != '0);
    snan_any = (nan_a && !fa[FRAC_W-1]) || (nan_b && !fb[FRAC_W-1]);
    inf_a  = (ea == EXP_ONES) && (fa == '0);
    inf_b  = (eb == EXP_ONES) && (fb == '0);
    zero_a = (a[FP_W-2:0] == '0);
    zero_b = (b[FP_W-2:0] == '0);
    a_big  = a[FP_W-2:0] >= b[FP_W-2:0];
    rm     = (rm_in > 3'd4) ? RM_RNE : rmode_e'(rm_in);

    ctl.rm      = rm;
    ctl.eff_sub = sa ^ sb;
    ctl.byp     = 1'b1;
    ctl.byp_flg = '0;
    ctl.byp_val = '0;
    if (nan_a || nan_b) begin
      ctl.byp_val = QNAN;
      ctl.byp_flg[FLG_NV] = snan_any;
    end else if (inf_a && inf_b) begin
      ctl.byp_val = ctl.eff_sub ? QNAN : a;
      ctl.byp_flg[FLG_NV] = ctl.eff_sub;
    end else if (inf_a || zero_b) begin
      ctl.byp_val = (zero_a && zero_b) ? {(ctl.eff_sub ? (rm == RM_RDN) : sa), {(FP_W-1){1'b0}}} : a;
    end else if (inf_b || zero_a) begin
      ctl.byp_val = {sb, b[FP_W-2:0]};
    end else begin
      ctl.byp = 1'b0;
    end

    el = a_big ? ea : eb;
    es = a_big ? eb : ea;
    sig_l = a_big ? {ea != '0, fa} : {eb != '0, fb};
    sig_s = a_big ? {eb != '0, fb} : {ea != '0, fa};
    if (el == '0) el = EXP_W'(1);
    if (es == '0) es = EXP_W'(1);
    ctl.sign = a_big ? sa : sb;
    ctl.exp  = el;
    diff     = el - es;
  end
endmodule

// File: rtl/fpadd_normround.sv
module fpadd_normround
  import fpadd_pkg::*;
(
  input  ctl_t             ctl,
  input  logic [SUM_W-1:0] sum,
  output logic [FP_W-1:0]  res,
  output logic [FLG_W-1:0] flags
);
  logic [ALN_W-1:0]  norm;
  logic [4:0]        lz;
  logic [EXP_W-1:0]  lim, sh;
  logic [EXP_W+1:0]  e;
  logic [SIG_W:0]    m_inc;
  logic [SIG_W-1:0]  mant;
  logic              inexact, rnd_carry, ovf_hit, to_inf;

  always_comb begin
    lz  = lead_zeros(sum[ALN_W-1:0]);
    lim = ctl.exp - EXP_W'(1);
    sh  = (EXP_W'(lz) < lim) ? EXP_W'(lz) : lim;
    if (sum[SUM_W-1]) begin
      norm = {sum[SUM_W-1:2], sum[1] | sum[0]};
      e    = {2'b00, ctl.exp} + 10'd1;
    end else begin
      norm = sum[ALN_W-1:0] << sh;
      e    = {2'b00, ctl.exp} - {2'b00, sh};
    end
    inexact   = norm[2] | norm[1] | norm[0];
    m_inc     = {1'b0, norm[ALN_W-1:XTRA_W]} +
                (SIG_W+1)'(rnd_incr(ctl.rm, ctl.sign, norm[XTRA_W], norm[2], norm[1] | norm[0]));
    rnd_carry = m_inc[SIG_W];
    mant      = rnd_carry ? m_inc[SIG_W:1] : m_inc[SIG_W-1:0];
    if (rnd_carry) e = e + 10'd1;
    ovf_hit   = (e >= {2'b00, EXP_ONES});
    to_inf    = (ctl.rm == RM_RNE) || (ctl.rm == RM_RMM) ||
                ((ctl.rm == RM_RDN) && ctl.sign) || ((ctl.rm == RM_RUP) && !ctl.sign);

    flags = '0;
    if (ctl.byp) begin
      res   = ctl.byp_val;
      flags = ctl.byp_flg;
    end else if (sum == '0) begin
      res = {(ctl.rm == RM_RDN), {(FP_W-1){1'b0}}};
    end else if (ovf_hit) begin
      res = to_inf ? {ctl.sign, EXP_ONES, {FRAC_W{1'b0}}}
                   : {ctl.sign, EXP_ONES - EXP_W'(1), {FRAC_W{1'b1}}};
      flags[FLG_OF] = 1'b1;
      flags[FLG_NX] = 1'b1;
    end else begin
      res = {ctl.sign, mant[SIG_W-1] ? e[EXP_W-1:0] : {EXP_W{1'b0}}, mant[FRAC_W-1:0]};
      flags[FLG_NX] = inexact;
    end
  end
endmodule

// File: rtl/fp32_addsub_pipe.sv
module fp32_addsub_pipe
  import fpadd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  in_a,
  input  logic [FP_W-1:0]  in_b,
  input  logic             in_sub,
  input  logic [2:0]       in_rm,
  output logic             out_valid,
  output logic [FP_W-1:0]  out_result,
  output logic [FLG_W-1:0] out_flags
);
  // Stage 1: decode and swap
  ctl_t             u_ctl, s1_ctl, s2_ctl, s3_ctl;
  logic [SIG_W-1:0] u_sig_l, u_sig_s, s1_sig_l, s1_sig_s;
  logic [EXP_W-1:0] u_diff, s1_diff;
  logic             s1_v, s2_v, s3_v;

  fpadd_unpack u_unpack (
    .a(in_a), .b(in_b), .sub(in_sub), .rm_in(in_rm),
    .ctl(u_ctl), .sig_l(u_sig_l), .sig_s(u_sig_s), .diff(u_diff)
  );

  // Stage 2: alignment with guard/round/sticky
  logic [ALN_W-1:0] s2_big, s2_small;

  // Stage 3: prefix add
  logic [ALN_W-1:0] ks_a, ks_b, ks_sum;
  logic             ks_cin, ks_cout;
  logic [SUM_W-1:0] s3_sum;

  assign ks_a   = s2_big;
  assign ks_cin = s2_ctl.eff_sub;
  assign ks_b   = s2_ctl.eff_sub ? ~s2_small : s2_small;

  fpadd_ks_adder #(.W(ALN_W)) u_ks (
    .a(ks_a), .b(ks_b), .cin(ks_cin), .sum(ks_sum), .cout(ks_cout)
  );

  // Stage 4: normalize and round
  logic [FP_W-1:0]  nr_res;
  logic [FLG_W-1:0] nr_flags;

  fpadd_normround u_nr (.ctl(s3_ctl), .sum(s3_sum), .res(nr_res), .flags(nr_flags));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0; out_valid <= 1'b0;
    end else begin
      s1_v <= in_valid; s2_v <= s1_v; s3_v <= s2_v; out_valid <= s3_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_ctl     <= u_ctl;
    s1_sig_l   <= u_sig_l;
    s1_sig_s   <= u_sig_s;
    s1_diff    <= u_diff;
    s2_ctl     <= s1_ctl;
    s2_big     <= {s1_sig_l, {XTRA_W{1'b0}}};
    s2_small   <= align_shift(s1_sig_s, s1_diff);
    s3_ctl     <= s2_ctl;
    s3_sum     <= s2_ctl.eff_sub ? {1'b0, ks_sum} : {ks_cout, ks_sum};
    out_result <= nr_res;
    out_flags  <= nr_flags;
  end

  // Cycles since reset, saturating, so the latency check never looks before reset.
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  a_r1_prefix_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !s2_ctl.byp) |->
      ({ks_cout, ks_sum} == ({1'b0, ks_a} + {1'b0, ks_b} + SUM_W'(ks_cin))));

  a_r4_canonical_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_result[FP_W-2:FRAC_W] == EXP_ONES) && (out_result[FRAC_W-1:0] != '0))
      |-> (out_result == QNAN));

  a_r5_invalid_gives_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[FLG_NV]) |-> (out_result == QNAN));

  a_r8_overflow_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[FLG_OF]) |-> (out_flags[FLG_NX] && !out_flags[FLG_NV]));

  a_r7_unused_flags: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[3] == 1'b0 && out_flags[1] == 1'b0));
endmodule

// File: tb/fp32_addsub_pipe_tb.sv
`timescale 1ns/1ps
module fp32_addsub_pipe_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        in_sub = 1'b0;
  logic [2:0]  in_rm = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [4:0]  out_flags;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fp32_addsub_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_sub(in_sub), .in_rm(in_rm), .out_valid(out_valid),
    .out_result(out_result), .out_flags(out_flags)
  );

  // {req, a, b, sub, rm, expected result, expected flags}; flags bit4 NV, bit2 OF, bit0 NX
  localparam int NV = 37;
  localparam logic [108:0] VECS [NV] = '{
    {4'd1,  32'h3F800000, 32'h3F800000, 1'b0, 3'd0, 32'h40000000, 5'h00}, // R1
    {4'd1,  32'h3FC00000, 32'h40200000, 1'b0, 3'd0, 32'h40800000, 5'h00}, // R1
    {4'd1,  32'h3F800000, 32'hC0000000, 1'b0, 3'd0, 32'hBF800000, 5'h00}, // R1
    {4'd2,  32'h40400000, 32'h3F800000, 1'b1, 3'd0, 32'h40000000, 5'h00}, // R2
    {4'd2,  32'h3F800000, 32'h40400000, 1'b1, 3'd0, 32'hC0000000, 5'h00}, // R2
    {4'd2,  32'h7F800000, 32'hFF800000, 1'b1, 3'd0, 32'h7F800000, 5'h00}, // R2
    {4'd4,  32'h7FC00001, 32'h3F800000, 1'b0, 3'd0, 32'h7FC00000, 5'h00}, // R4
    {4'd4,  32'h7F800001, 32'h3F800000, 1'b0, 3'd0, 32'h7FC00000, 5'h10}, // R4
    {4'd4,  32'h3F800000, 32'hFF800001, 1'b0, 3'd0, 32'h7FC00000, 5'h10}, // R4
    {4'd5,  32'h7F800000, 32'h7F800000, 1'b1, 3'd0, 32'h7FC00000, 5'h10}, // R5
    {4'd5,  32'hFF800000, 32'h3F800000, 1'b0, 3'd0, 32'hFF800000, 5'h00}, // R5
    {4'd6,  32'h3F800000, 32'h33800000, 1'b0, 3'd0, 32'h3F800000, 5'h01}, // R6
    {4'd6,  32'h3F800000, 32'h33800000, 1'b0, 3'd3, 32'h3F800001, 5'h01}, // R6
    {4'd6,  32'h3F800000, 32'h33800000, 1'b0, 3'd4, 32'h3F800001, 5'h01}, // R6
    {4'd6,  32'h3F800000, 32'h33C00000, 1'b0, 3'd0, 32'h3F800001, 5'h01}, // R6
    {4'd6,  32'h3F800000, 32'h33C00000, 1'b0, 3'd1, 32'h3F800000, 5'h01}, // R6
    {4'd6,  32'hBF800000, 32'hB3C00000, 1'b0, 3'd2, 32'hBF800001, 5'h01}, // R6
    {4'd6,  32'hBF800000, 32'hB3C00000, 1'b0, 3'd3, 32'hBF800000, 5'h01}, // R6
    {4'd6,  32'h3F800000, 32'h33800000, 1'b0, 3'd5, 32'h3F800000, 5'h01}, // R6
    {4'd7,  32'h3F800000, 32'h33800001, 1'b1, 3'd0, 32'h3F7FFFFF, 5'h01}, // R7
    {4'd7,  32'h3F800001, 32'h3F800000, 1'b1, 3'd0, 32'h34000000, 5'h00}, // R7
    {4'd8,  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 3'd0, 32'h7F800000, 5'h05}, // R8
    {4'd8,  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 3'd1, 32'h7F7FFFFF, 5'h05}, // R8
    {4'd8,  32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 3'd3, 32'hFF7FFFFF, 5'h05}, // R8
    {4'd8,  32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 3'd2, 32'hFF800000, 5'h05}, // R8
    {4'd9,  32'h3F800000, 32'hBF800000, 1'b0, 3'd0, 32'h00000000, 5'h00}, // R9
    {4'd9,  32'h3F800000, 32'hBF800000, 1'b0, 3'd2, 32'h80000000, 5'h00}, // R9
    {4'd9,  32'h3F800000, 32'h3F800000, 1'b1, 3'd2, 32'h80000000, 5'h00}, // R9
    {4'd9,  32'h00000000, 32'h80000000, 1'b0, 3'd0, 32'h00000000, 5'h00}, // R9
    {4'd9,  32'h00000000, 32'h80000000, 1'b0, 3'd2, 32'h80000000, 5'h00}, // R9
    {4'd9,  32'h80000000, 32'h00000000, 1'b1, 3'd0, 32'h80000000, 5'h00}, // R9
    {4'd10, 32'h00000001, 32'h00000001, 1'b0, 3'd0, 32'h00000002, 5'h00}, // R10
    {4'd10, 32'h00400000, 32'h00400000, 1'b0, 3'd0, 32'h00800000, 5'h00}, // R10
    {4'd10, 32'h00800000, 32'h00000001, 1'b1, 3'd0, 32'h007FFFFF, 5'h00}, // R10
    {4'd2,  32'h00000000, 32'h3F800000, 1'b1, 3'd0, 32'hBF800000, 5'h00}, // R2
    {4'd11, 32'h3FFFFFFF, 32'h33800000, 1'b0, 3'd0, 32'h40000000, 5'h01}, // R11
    {4'd11, 32'h7F7FFFFF, 32'h73000000, 1'b0, 3'd0, 32'h7F800000, 5'h05}  // R11
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [36:0] act, input logic [36:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic [2:0] rm);
    in_valid = v; in_a = a; in_b = b; in_sub = s; in_rm = rm;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(out_valid === 1'b0, "R12", "out_valid in reset", {36'd0, out_valid}, 37'd0);
    rst_n = 1'b1;

    // Table walk, back to back, one operation per cycle (R3 throughput)
    for (int i = 0; i < NV + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        logic [108:0] v;
        string rq;
        v  = VECS[i-4];
        rq = $sformatf("R%0d", v[108:105]);
        check(out_valid === 1'b1, "R3", "out_valid in stream", {36'd0, out_valid}, 37'd1);
        check({out_result, out_flags} === v[36:0], rq,
              $sformatf("vector %0d result/flags", i - 4), {out_result, out_flags}, v[36:0]);
      end
      if (i < NV) drive(1'b1, VECS[i][104:73], VECS[i][72:41], VECS[i][40], VECS[i][39:37]);
      else        drive(1'b0, '0, '0, 1'b0, 3'd0);
    end

    // R3: single operation, exact latency
    repeat (2) @(negedge clk);
    drive(1'b1, 32'h40000000, 32'h40000000, 1'b0, 3'd0);
    @(negedge clk);
    drive(1'b0, '0, '0, 1'b0, 3'd0);
    for (int k = 0; k < 3; k++) begin
      check(out_valid === 1'b0, "R3", "out_valid before latency", {36'd0, out_valid}, 37'd0);
      @(negedge clk);
    end
    check(out_valid === 1'b1, "R3", "out_valid at latency", {36'd0, out_valid}, 37'd1);
    check(out_result === 32'h40800000, "R3", "single result", {5'd0, out_result}, {5'd0, 32'h40800000});
    @(negedge clk);
    check(out_valid === 1'b0, "R3", "out_valid after single", {36'd0, out_valid}, 37'd0);

    // R12: reset drops operations in flight
    drive(1'b1, 32'h3F800000, 32'h3F800000, 1'b0, 3'd0);
    repeat (3) @(negedge clk);
    drive(1'b0, '0, '0, 1'b0, 3'd0);
    rst_n = 1'b0;
    #1;
    check(out_valid === 1'b0, "R12", "out_valid at reset", {36'd0, out_valid}, 37'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R12", "no stale output", {36'd0, out_valid}, 37'd0);
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R3 watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule